// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

This block is a 32-bit processor core without pipelining. Each instruction passes through a fixed order of phases: fetch, decode with register read, execute or address calculation, memory access or branch resolution, and write-back. The core keeps its working values in internal registers: the program counter, the next program counter, the instruction register, two operand latches, the sign-extended immediate, the ALU result, the branch condition and the loaded data word. Beside these it has a register file of 32 words. Only one phase is active in any cycle, so a single combinational ALU and a single memory port are enough.

The core has one word-wide memory port that serves both instruction fetch and data access. The port address is the program counter in every phase except the memory phase, where it is the ALU result. Memory reads are expected to be combinational, and a write takes effect on the clock edge that ends the memory phase. The instruction subset covers four register-register operations, add-immediate, load word, store word, and two branches that test a register against zero. A halt instruction stops the core so that a testbench can inspect memory.

Top module: `mc_core`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, the core is in fetch with a program counter of 0: mem_addr is 0, mem_we is 0 and halted is 0.
- R2: During fetch, mem_addr equals the program counter. The fetched word is latched as the instruction, and the next program counter is the program counter plus 4. A five-cycle instruction at address 0 is followed by a fetch from address 4 in the sixth cycle.
- R3: Instruction fields use bit 31 as the most significant bit. The opcode is bits 31:26. The first source register is bits 25:21, and the second source or immediate-class destination is bits 20:16. The register-register destination is bits 15:11, and the immediate is bits 15:0, sign-extended to 32 bits.
- R4: Opcode 0x00 is a register-register operation selected by bits 1:0: 0 add, 1 subtract (first minus second), 2 bitwise AND, 3 bitwise OR. The result is written to the register in bits 15:11.
- R5: Opcode 0x08 adds the sign-extended immediate to the first source and writes the sum to the register in bits 20:16.
- R6: Opcode 0x23 loads the word at byte address first source plus immediate into the register in bits 20:16.
- R7: Opcode 0x2B writes the register in bits 20:16 to the byte address first source plus immediate. mem_we is high only during that instruction's memory phase, which is its fourth cycle.
- R8: Opcode 0x04 branches when the first source equals zero, and opcode 0x05 branches when it is nonzero. The target is the next program counter plus the immediate, without scaling. A branch that is not taken continues at the next program counter, and no branch writes a register.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Register-register, add-immediate and load instructions take 5 cycles. Stores, branches and undefined opcodes take 4 cycles.
- R11: Opcode 0x3F halts the core two cycles after its fetch begins. From then on, halted stays high, mem_we stays low and mem_addr holds the address of the halt instruction.
- R12: Any other opcode writes neither a register nor memory, and execution continues at the next program counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 32 | Byte address of the shared memory port |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Read data, combinational from mem_addr |
| mem_we | output | 1 | Write strobe for the current cycle |
| halted | output | 1 | High once a halt instruction has been decoded |

## Verification
Register contents can only be seen through the port, so every program ends by storing all 32 registers to a dump area. The bench then compares the whole memory image with its own instruction-level interpreter, and also compares the total cycle count up to halt. The hardest case to reach is a branch whose target depends on an unscaled negative immediate combined with a condition register that changes inside a loop. A directed countdown loop produces this case, and a taken skip of exactly one instruction separates unscaled targets from scaled ones. Random programs mix ALU operations, loads and stores in a scratch area, and forward branches on random registers, so that taken and not-taken paths both accumulate into the cycle count.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_N  = 32;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;
  localparam logic [5:0] OP_BEQZ = 6'h04;
  localparam logic [5:0] OP_BNEZ = 6'h05;
  localparam logic [5:0] OP_HALT = 6'h3F;

  localparam logic [1:0] FN_ADD = 2'd0;
  localparam logic [1:0] FN_SUB = 2'd1;
  localparam logic [1:0] FN_AND = 2'd2;
  localparam logic [1:0] FN_OR  = 2'd3;

  typedef enum logic [2:0] {
    PH_IF, PH_ID, PH_EX, PH_MEM, PH_WB, PH_HALT
  } phase_t;

  typedef enum logic [2:0] {
    IC_RR, IC_RI, IC_LD, IC_ST, IC_BR, IC_HALT, IC_NOP
  } iclass_t;

  function automatic iclass_t classify(input logic [5:0] op);
    case (op)
      OP_RR:            return IC_RR;
      OP_ADDI:          return IC_RI;
      OP_LW:            return IC_LD;
      OP_SW:            return IC_ST;
      OP_BEQZ, OP_BNEZ: return IC_BR;
      OP_HALT:          return IC_HALT;
      default:          return IC_NOP;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] alu_eval(input logic [1:0] fn,
                                                 input logic [WORD_W-1:0] x,
                                                 input logic [WORD_W-1:0] y);
    case (fn)
      FN_ADD:  return x + y;
      FN_SUB:  return x - y;
      FN_AND:  return x & y;
      default: return x | y;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] sext16(input logic [15:0] v);
    return {{(WORD_W-16){v[15]}}, v};
  endfunction
endpackage

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned N    = REG_N,
  parameter int unsigned NRD  = 2,
  localparam int unsigned AW  = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NRD-1:0][AW-1:0] raddr,
  output logic [NRD-1:0][W-1:0]  rdata,
  input  logic                   we,
  input  logic [AW-1:0]          waddr,
  input  logic [W-1:0]           wdata
);
  logic [W-1:0] regs [N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(N); i++) regs[i] <= '0;
    end else if (we && waddr != '0) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar p = 0; p < int'(NRD); p++) begin : g_rd
    assign rdata[p] = (raddr[p] == '0) ? '0 : regs[raddr[p]];
  end
endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t cls,
  output phase_t  phase,
  output logic    ir_ld,
  output logic    ab_ld,
  output logic    alu_ld,
  output logic    lmd_ld,
  output logic    st_we,
  output logic    rf_we,
  output logic    retire
);
  phase_t nxt;
  logic   short_cls;

  assign short_cls = (cls == IC_ST) || (cls == IC_BR) || (cls == IC_NOP);

  always_comb begin
    nxt = phase;
    case (phase)
      PH_IF:   nxt = PH_ID;
      PH_ID:   nxt = (cls == IC_HALT) ? PH_HALT : PH_EX;
      PH_EX:   nxt = PH_MEM;
      PH_MEM:  nxt = short_cls ? PH_IF : PH_WB;
      PH_WB:   nxt = PH_IF;
      default: nxt = PH_HALT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase <= PH_IF;
    else        phase <= nxt;
  end

  assign ir_ld  = (phase == PH_IF);
  assign ab_ld  = (phase == PH_ID);
  assign alu_ld = (phase == PH_EX);
  assign lmd_ld = (phase == PH_MEM) && (cls == IC_LD);
  assign st_we  = (phase == PH_MEM) && (cls == IC_ST);
  assign rf_we  = (phase == PH_WB);
  assign retire = ((phase == PH_MEM) && short_cls) || (phase == PH_WB);
endmodule

// File: rtl/mc_exec.sv
module mc_exec
  import mc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  iclass_t      cls,
  input  logic [1:0]   fn,
  input  logic         test_ne,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] imm,
  input  logic [W-1:0] npc,
  output logic [W-1:0] res,
  output logic         cond
);
  logic [W-1:0] opa;
  logic [W-1:0] opb;
  logic [1:0]   fsel;
  logic         a_zero;

  assign opa    = (cls == IC_BR) ? npc : a;
  assign opb    = (cls == IC_RR) ? b : imm;
  assign fsel   = (cls == IC_RR) ? fn : FN_ADD;
  assign res    = alu_eval(fsel, opa, opb);
  assign a_zero = (a == '0);
  assign cond   = test_ne ? !a_zero : a_zero;
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int unsigned W    = WORD_W,
  parameter int unsigned NREG = REG_N,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata,
  output logic         mem_we,
  output logic         halted
);
  logic [W-1:0] pc_q, npc_q, ir_q, a_q, b_q, imm_q, alu_q, lmd_q;
  logic         cond_q;

  phase_t  phase;
  iclass_t cls;
  logic    ir_ld, ab_ld, alu_ld, lmd_ld, st_we, rf_we, retire;
  logic    branch_taken;

  logic [5:0]    f_op;
  logic [AW-1:0] f_src1, f_src2, f_rdst;
  logic [1:0]    f_fn;

  assign f_op   = ir_q[31:26];
  assign f_src1 = ir_q[25:21];
  assign f_src2 = ir_q[20:16];
  assign f_rdst = ir_q[15:11];
  assign f_fn   = ir_q[1:0];
  assign cls    = classify(f_op);

  logic [1:0][AW-1:0] rf_raddr;
  logic [1:0][W-1:0]  rf_rdata;
  logic [AW-1:0]      rf_waddr;
  logic [W-1:0]       rf_wdata;

  assign rf_raddr[0] = f_src1;
  assign rf_raddr[1] = f_src2;
  assign rf_waddr    = (cls == IC_RR) ? f_rdst : f_src2;
  assign rf_wdata    = (cls == IC_LD) ? lmd_q : alu_q;

  mc_regfile #(.W(W), .N(NREG), .NRD(2)) u_rf (
    .clk   (clk),
    .rst_n (rst_n),
    .raddr (rf_raddr),
    .rdata (rf_rdata),
    .we    (rf_we),
    .waddr (rf_waddr),
    .wdata (rf_wdata)
  );

  mc_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .cls    (cls),
    .phase  (phase),
    .ir_ld  (ir_ld),
    .ab_ld  (ab_ld),
    .alu_ld (alu_ld),
    .lmd_ld (lmd_ld),
    .st_we  (st_we),
    .rf_we  (rf_we),
    .retire (retire)
  );

  logic [W-1:0] ex_res;
  logic         ex_cond;

  mc_exec #(.W(W)) u_exec (
    .cls     (cls),
    .fn      (f_fn),
    .test_ne (f_op[0]),
    .a       (a_q),
    .b       (b_q),
    .imm     (imm_q),
    .npc     (npc_q),
    .res     (ex_res),
    .cond    (ex_cond)
  );

  assign branch_taken = (cls == IC_BR) && cond_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= '0;
      npc_q  <= '0;
      ir_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      imm_q  <= '0;
      alu_q  <= '0;
      lmd_q  <= '0;
      cond_q <= 1'b0;
    end else begin
      if (ir_ld) begin
        ir_q  <= mem_rdata;
        npc_q <= pc_q + W'(4);
      end
      if (ab_ld) begin
        a_q   <= rf_rdata[0];
        b_q   <= rf_rdata[1];
        imm_q <= sext16(ir_q[15:0]);
      end
      if (alu_ld) begin
        alu_q  <= ex_res;
        cond_q <= ex_cond;
      end
      if (lmd_ld) lmd_q <= mem_rdata;
      if (retire) pc_q <= branch_taken ? alu_q : npc_q;
    end
  end

  assign mem_addr  = (phase == PH_MEM) ? alu_q : pc_q;
  assign mem_wdata = b_q;
  assign mem_we    = st_we;
  assign halted    = (phase == PH_HALT);
endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] mem_addr,
  input logic         mem_we,
  input logic         halted,
  input phase_t       phase,
  input iclass_t      cls,
  input logic [W-1:0] pc_q,
  input logic [W-1:0] npc_q,
  input logic [W-1:0] alu_q,
  input logic [W-1:0] ir_q,
  input logic [W-1:0] a_q,
  input logic         rf_we,
  input logic         retire,
  input logic         branch_taken
);
  AST_FETCH_AT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IF) |-> (mem_addr == pc_q)); // R2

  AST_NPC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IF) |=> (npc_q == $past(pc_q) + W'(4))); // R2

  AST_WE_STORE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (phase == PH_MEM && cls == IC_ST)); // R7

  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && branch_taken) |=> (pc_q == $past(alu_q))); // R8

  AST_NO_BR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (cls != IC_BR && cls != IC_ST && cls != IC_NOP)); // R8

  AST_R0_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ID && ir_q[25:21] == 5'd0) |=> (a_q == '0)); // R9

  AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !branch_taken) |=> (pc_q == $past(npc_q))); // R10

  AST_SHORT_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MEM && (cls == IC_ST || cls == IC_BR || cls == IC_NOP))
      |=> (phase == PH_IF)); // R10

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_we && $stable(mem_addr))); // R11
endmodule

bind mc_core mc_core_chk #(.W(W)) u_chk (.*);

// File: tb/mc_core_tb_top.sv
`timescale 1ns/1ps
module mc_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        mem_we, halted;

  always #2 clk = ~clk;

  mc_core dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .halted    (halted)
  );

  logic [31:0] ram  [256];
  logic [31:0] img  [256];
  logic [31:0] gold [256];
  logic [31:0] greg [32];
  logic [31:0] tr_addr [2048];
  logic        tr_we   [2048];
  int total = 0;
  int bad   = 0;
  int plen  = 0;

  assign mem_rdata = ram[mem_addr[9:2]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) ram[i] <= img[i];
    end else if (mem_we) begin
      ram[mem_addr[9:2]] <= mem_wdata;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // instruction encoders
  function automatic logic [31:0] e_rr(input logic [1:0] fn, input int d, input int s, input int t);
    return {6'h00, 5'(s), 5'(t), 5'(d), 9'd0, fn};
  endfunction
  function automatic logic [31:0] e_i(input logic [5:0] op, input int s, input int t, input int imm);
    return {op, 5'(s), 5'(t), 16'(imm)};
  endfunction

  task automatic emit(input logic [31:0] w);
    img[plen] = w;
    plen++;
  endtask

  task automatic clear_img();
    for (int i = 0; i < 256; i++) img[i] = 32'(i) * 32'h9E37 ^ 32'h5A5A0000;
    plen = 0;
  endtask

  task automatic dump_regs();
    for (int r = 0; r < 32; r++) emit(e_i(6'h2B, 0, r, 32'h200 + 4 * r));
    emit(e_i(6'h3F, 0, 0, 0));
  endtask

  function automatic logic [31:0] ref_op(input logic [1:0] fn, input logic [31:0] x, input logic [31:0] y);
    case (fn)
      2'd0: return x + y;
      2'd1: return x + (~y + 32'd1);
      2'd2: return x & y;
      default: return x | y;
    endcase
  endfunction

  // instruction-level interpreter
  task automatic model_run(output int cyc, output logic [31:0] halt_pc);
    logic [31:0] pc, ir, imm, va, vb, npc, ea;
    logic [5:0]  op;
    int s, t, d;
    pc = 0; cyc = 0; halt_pc = 32'hFFFF_FFFF;
    for (int i = 0; i < 32; i++) greg[i] = 0;
    for (int i = 0; i < 256; i++) gold[i] = img[i];
    for (int step = 0; step < 3000; step++) begin
      ir  = gold[pc[9:2]];
      op  = ir[31:26];
      s   = int'(ir[25:21]); t = int'(ir[20:16]); d = int'(ir[15:11]);
      imm = {{16{ir[15]}}, ir[15:0]};
      va  = greg[s]; vb = greg[t];
      npc = pc + 4;
      ea  = va + imm;
      case (op)
        6'h00: begin if (d != 0) greg[d] = ref_op(ir[1:0], va, vb); cyc += 5; pc = npc; end
        6'h08: begin if (t != 0) greg[t] = ea; cyc += 5; pc = npc; end
        6'h23: begin if (t != 0) greg[t] = gold[ea[9:2]]; cyc += 5; pc = npc; end
        6'h2B: begin gold[ea[9:2]] = vb; cyc += 4; pc = npc; end
        6'h04: begin cyc += 4; pc = (va == 0) ? npc + imm : npc; end
        6'h05: begin cyc += 4; pc = (va != 0) ? npc + imm : npc; end
        6'h3F: begin cyc += 2; halt_pc = pc; return; end
        default: begin cyc += 4; pc = npc; end
      endcase
    end
  endtask

  task automatic run_prog(input string reqs);
    int exp_cyc, k;
    logic [31:0] hpc, hold_addr;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_addr == 0 && !mem_we && !halted, "R1", "reset state addr",
        mem_addr, 32'h0);
    model_run(exp_cyc, hpc);
    rst_n = 1'b1;
    k = 0;
    while (1) begin
      if (k < 2048) begin tr_addr[k] = mem_addr; tr_we[k] = mem_we; end
      @(posedge clk);
      k++;
      @(negedge clk);
      if (halted) break;
      if (k >= 5000) begin
        chk(1'b0, "R11", "run did not halt", 32'(k), 32'(exp_cyc));
        break;
      end
    end
    chk(k == exp_cyc, "R10", "cycles to halt", 32'(k), 32'(exp_cyc));
    for (int i = 0; i < 256; i++)
      chk(ram[i] === gold[i], reqs, $sformatf("mem word %0d", i), ram[i], gold[i]);
    hold_addr = mem_addr;
    chk(hold_addr == hpc, "R11", "halt address held", hold_addr, hpc);
    repeat (6) begin
      @(negedge clk);
      chk(halted && !mem_we && mem_addr == hold_addr, "R11", "quiet after halt",
          {mem_we, halted, mem_addr[29:0]}, {2'b01, hold_addr[29:0]});
    end
  endtask

  task automatic rand_prog();
    int n, skip, r, sa;
    logic [5:0] op;
    clear_img();
    for (int i = 0; i < 8; i++)
      emit(e_i(6'h08, 0, int'($urandom_range(31, 0)), int'($urandom_range(65535, 0))));
    n = 0;
    while (n < 20) begin
      r = int'($urandom_range(9, 0));
      sa = 32'h300 + 4 * int'($urandom_range(31, 0));
      if (r < 4)
        emit(e_rr(2'($urandom_range(3, 0)), int'($urandom_range(31, 0)),
                  int'($urandom_range(31, 0)), int'($urandom_range(31, 0))));
      else if (r < 6)
        emit(e_i(6'h08, int'($urandom_range(31, 0)), int'($urandom_range(31, 0)),
                 int'($urandom_range(65535, 0))));
      else if (r == 6)
        emit(e_i(6'h2B, 0, int'($urandom_range(31, 0)), sa));
      else if (r == 7)
        emit(e_i(6'h23, 0, int'($urandom_range(31, 0)), sa));
      else begin
        skip = int'($urandom_range(2, 0));
        op = (r == 8) ? 6'h04 : 6'h05;
        emit(e_i(op, int'($urandom_range(31, 0)), 0, 4 * skip));
      end
      n++;
    end
    dump_regs();
  endtask

  initial begin
    void'($urandom(32'h00C0_FFEE));

    // directed: arithmetic, sign extension, register 0
    clear_img();
    emit(e_i(6'h08, 0, 1, 32'h1234));
    emit(e_i(6'h08, 0, 2, -5));
    emit(e_rr(2'd0, 3, 1, 2));
    emit(e_rr(2'd1, 4, 2, 1));
    emit(e_rr(2'd2, 5, 1, 2));
    emit(e_rr(2'd3, 6, 1, 2));
    emit(e_i(6'h08, 1, 0, 7));
    emit(e_rr(2'd0, 0, 1, 1));
    emit(e_rr(2'd0, 7, 0, 2));
    dump_regs();
    run_prog("R3 R4 R5 R9");
    chk(tr_addr[0] == 32'h0, "R1", "first fetch address", tr_addr[0], 32'h0);
    chk(tr_addr[4] == 32'h0, "R2", "addr during write-back", tr_addr[4], 32'h0);
    chk(tr_addr[5] == 32'h4, "R2", "second fetch address", tr_addr[5], 32'h4);
    chk(tr_addr[10] == 32'h8, "R2", "third fetch address", tr_addr[10], 32'h8);
    chk(gold[32'h200/4 + 2] == 32'hFFFF_FFFB, "R5", "sign-extended immediate",
        gold[32'h200/4 + 2], 32'hFFFF_FFFB);

    // directed: loads and stores, store timing
    clear_img();
    emit(e_i(6'h2B, 0, 0, 32'h300));
    emit(e_i(6'h08, 0, 1, 32'h190));
    emit(e_i(6'h23, 1, 2, -16));
    emit(e_i(6'h23, 1, 3, 4));
    emit(e_rr(2'd0, 4, 2, 3));
    emit(e_i(6'h2B, 1, 4, 0));
    emit(e_i(6'h2B, 1, 2, 8));
    emit(e_i(6'h2B, 0, 4, 32'h1A0));
    emit(e_i(6'h23, 0, 5, 32'h1A0));
    emit(e_i(6'h2B, 0, 5, 32'h1A4));
    dump_regs();
    run_prog("R6 R7");
    chk(tr_we[3] && tr_addr[3] == 32'h300, "R7", "store in fourth cycle",
        {tr_we[3], tr_addr[3][30:0]}, {1'b1, 31'h300});
    chk(!tr_we[2] && !tr_we[4], "R7", "strobe only in memory phase",
        {31'd0, tr_we[2] | tr_we[4]}, 32'h0);
    chk(tr_addr[4] == 32'h4, "R10", "store retires after four cycles",
        tr_addr[4], 32'h4);

    // directed: branches and undefined opcode
    clear_img();
    emit(e_i(6'h08, 0, 1, 3));
    emit(e_i(6'h08, 0, 2, 0));
    emit(e_i(6'h08, 1, 1, -1));
    emit(e_i(6'h08, 2, 2, 5));
    emit(e_i(6'h05, 1, 0, -12));
    emit(e_i(6'h04, 1, 0, 4));
    emit(e_i(6'h08, 2, 2, 1000));
    emit(e_i(6'h05, 1, 0, 8));
    emit(e_i(6'h04, 2, 0, 8));
    emit(e_i(6'h3A, 2, 3, 32'h0123));
    emit(e_i(6'h2B, 0, 2, 32'h100));
    emit(e_i(6'h2B, 0, 1, 32'h104));
    dump_regs();
    run_prog("R8 R12");
    chk(gold[32'h100/4] == 32'd15, "R8", "loop and skip result",
        gold[32'h100/4], 32'd15);

    // random programs
    for (int p = 0; p < 6; p++) begin
      rand_prog();
      run_prog("R3 R4 R5 R6 R7 R8 R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule